// File: doc/BRIEF.md
# Programmable GPIO input debounce filter

This block conditions one GPIO pad input before its level is published as the pin status bit. The raw pad signal first passes through a two-flop synchronizer. A filter then removes short pulses using a time base taken from a slow real-time clock. The slow clock arrives as a one-cycle enable, `rtc_pulse`, in the fast clock domain. A prescaler turns it into debounce ticks of 2, 8, 512 or 2048 slow pulses. A 4-bit count sets how many ticks a new level must hold.

Software programs the block through an 8-bit configuration register. The register holds a count, a unit bit, a large bit and a 2-bit mode. The mode either turns filtering off or selects one of three filters:

- reject glitches in both directions;
- let low levels through at once and delay only rises;
- the mirror of the previous mode.

Each write produces a one-cycle pulse for a neighbouring aggregator. Each write also restarts any debounce in progress.

Top module: `gpio_debounce_filter`

## Requirements
- R1: While reset is held, `pin_status` is 0, `cfg_rdata` is 0 and `cfg_written` is 0.
- R2: Configuration layout: `[3:0]` count N, `[4]` unit, `[5]` large, `[7:6]` mode. A value written with `cfg_we` high at a clock edge reads back unchanged on `cfg_rdata` after that edge.
- R3: `cfg_written` is high for exactly the one cycle that follows each edge at which `cfg_we` was high, and is low otherwise.
- R4: Mode 00 disables filtering. A pad change is seen on `pin_status` after the third rising clock edge, counting from the first edge after the change.
- R5: The tick length L is set by {large, unit}: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048 `rtc_pulse` cycles.
- R6: The debounce time is T×L slow pulses. T equals N for N from 1 to 15, and T equals 16 when N is 0.
- R7: Mode 01 delays both edges. With `rtc_pulse` high in every cycle, `pin_status` changes at edge T×L+2 after a pad change. While `rtc_pulse` stays low, no progress is made.
- R8: If the synchronized input returns to the current `pin_status` level before the time runs out, all progress is dropped. A later change needs the full time again.
- R9: Mode 10 lets a falling input through within 3 edges and delays a rise by the full debounce time.
- R10: Mode 11 lets a rising input through within 3 edges and delays a fall by the full debounce time.
- R11: A configuration write discards any debounce in progress. Counting starts again on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | 1 | Raw asynchronous pad level |
| rtc_pulse | input | 1 | One-cycle enable marking each slow-clock cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration value to write |
| cfg_rdata | output | 8 | Current configuration value |
| cfg_written | output | 1 | One-cycle pulse after each write |
| pin_status | output | 1 | Filtered pin level |

## Verification
Two situations are hard to reach from the ports: progress thrown away after an almost complete glitch, and a count restarted partway by a configuration write. The bench builds a glitch exactly one slow pulse shorter than the debounce time, then releases it. It then measures a fresh transition, which must again take the full time. For the write case, the bench writes the configuration several edges into a pending transition. It then checks that the remaining delay is the full time measured from the write, not the remainder of the earlier count. The slow-clock stall and the two largest tick sizes are reached by holding `rtc_pulse` low, or high in every cycle, which gives exact edge counts.

// File: rtl/gdf_pkg.sv
package gdf_pkg;
    typedef enum logic [1:0] {
        DB_OFF       = 2'b00,
        DB_BOTH      = 2'b01,
        DB_KEEP_LOW  = 2'b10,
        DB_KEEP_HIGH = 2'b11
    } db_mode_e;
endpackage

// File: rtl/gdf_sync.sv
module gdf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/gdf_cfg_reg.sv
module gdf_cfg_reg #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg,
    output logic             written
);
    typedef struct packed {
        logic [CFG_W-1:0] value;
        logic             pulse;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pulse = we;
        if (we) st_d.value = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg     = st_q.value;
    assign written = st_q.pulse;

    assert_write_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> written);
    assert_no_stray_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> !written);
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cfg == $past(wdata));
endmodule

// File: rtl/gdf_tick_gen.sv
module gdf_tick_gen #(
    parameter int LEN_0 = 2,
    parameter int LEN_1 = 8,
    parameter int LEN_2 = 512,
    parameter int LEN_3 = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rtc_pulse,
    input  logic       clear,
    input  logic [1:0] len_sel,
    output logic       tick
);
    localparam int PS_W = $clog2(LEN_3);

    typedef struct packed {
        logic [PS_W-1:0] phase;
    } ps_st_t;

    ps_st_t st_d, st_q;
    logic [PS_W-1:0] last;

    always_comb begin
        case (len_sel)
            2'd0:    last = PS_W'(LEN_0 - 1);
            2'd1:    last = PS_W'(LEN_1 - 1);
            2'd2:    last = PS_W'(LEN_2 - 1);
            default: last = PS_W'(LEN_3 - 1);
        endcase
    end

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clear) begin
            st_d.phase = '0;
        end else if (rtc_pulse) begin
            if (st_q.phase >= last) begin
                st_d.phase = '0;
                tick       = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_tick_needs_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> rtc_pulse);
    assert_clear_resets_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tick || last == '0);
endmodule

// File: rtl/gdf_filter.sv
module gdf_filter
    import gdf_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_in,
    input  db_mode_e         mode,
    input  logic [CNT_W-1:0] count,
    input  logic             tick,
    input  logic             cfg_we,
    output logic             restart,
    output logic             level
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic differ, immediate;

    always_comb begin
        st_d      = st_q;
        differ    = (s_in != st_q.level);
        immediate = (mode == DB_OFF) ||
                    (mode == DB_KEEP_LOW  && !s_in) ||
                    (mode == DB_KEEP_HIGH &&  s_in);
        restart   = !differ || immediate || cfg_we;
        if (differ && immediate) begin
            st_d.level = s_in;
            st_d.cnt   = '0;
        end else if (restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == count - ONE) begin
                st_d.level = s_in;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;

    assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DB_OFF) |=> level == $past(s_in));
    assert_low_immediate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DB_KEEP_LOW && !s_in) |=> !level);
    assert_high_immediate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DB_KEEP_HIGH && s_in) |=> level);
    assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DB_BOTH && !tick) |=> $stable(level));
    assert_equal_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DB_BOTH && s_in == level) |=> $stable(level));
endmodule

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter
    import gdf_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_0       = 2,
    parameter int LEN_1       = 8,
    parameter int LEN_2       = 512,
    parameter int LEN_3       = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_in,
    input  logic             rtc_pulse,
    input  logic             cfg_we,
    input  logic [CNT_W+3:0] cfg_wdata,
    output logic [CNT_W+3:0] cfg_rdata,
    output logic             cfg_written,
    output logic             pin_status
);
    localparam int CFG_W    = CNT_W + 4;
    localparam int UNIT_BIT = CNT_W;
    localparam int BIG_BIT  = CNT_W + 1;
    localparam int MODE_LO  = CNT_W + 2;

    logic [CFG_W-1:0] cfg;
    logic             s_sync;
    logic             tick;
    logic             restart;
    db_mode_e         mode;

    gdf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .q_out (s_sync)
    );

    gdf_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .cfg     (cfg),
        .written (cfg_written)
    );

    assign mode = db_mode_e'(cfg[MODE_LO +: 2]);

    gdf_tick_gen #(
        .LEN_0(LEN_0), .LEN_1(LEN_1), .LEN_2(LEN_2), .LEN_3(LEN_3)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .rtc_pulse (rtc_pulse),
        .clear     (restart),
        .len_sel   ({cfg[BIG_BIT], cfg[UNIT_BIT]}),
        .tick      (tick)
    );

    gdf_filter #(.CNT_W(CNT_W)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_in    (s_sync),
        .mode    (mode),
        .count   (cfg[CNT_W-1:0]),
        .tick    (tick),
        .cfg_we  (cfg_we),
        .restart (restart),
        .level   (pin_status)
    );

    assign cfg_rdata = cfg;
endmodule

// File: tb/tb_gpio_debounce_filter.sv
module tb_gpio_debounce_filter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pad_in;
    logic       rtc_pulse;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       cfg_written;
    logic       pin_status;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    gpio_debounce_filter dut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .rtc_pulse(rtc_pulse),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_written(cfg_written), .pin_status(pin_status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input int sel);
        case (sel)
            0: return 2;
            1: return 8;
            2: return 512;
            default: return 2048;
        endcase
    endfunction

    function automatic int ticks_of(input int n);
        return (n == 0) ? 16 : n;
    endfunction

    function automatic logic [7:0] pack(input int mode, input int sel, input int n);
        return {mode[1:0], sel[1], sel[0], n[3:0]};
    endfunction

    task automatic wait_change(input int maxe, output int n);
        logic prev;
        prev = pin_status;
        n = 0;
        for (int i = 1; i <= maxe; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (pin_status !== prev) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_written === 1'b1, "R3 pulse after write", int'(cfg_written), 1);
        chk(cfg_rdata === v, "R2 readback", int'(cfg_rdata), int'(v));
        @(posedge clk);
        @(negedge clk);
        chk(cfg_written === 1'b0, "R3 pulse one cycle", int'(cfg_written), 0);
    endtask

    task automatic toggle_and_measure(input int exp, input string req);
        int n;
        pad_in = ~pad_in;
        wait_change(exp + 10, n);
        chk(n == exp, req, n, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int full;
        int n;
        bit stayed;
        rst_n = 1'b0; pad_in = 1'b0; rtc_pulse = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(pin_status === 1'b0, "R1 pin_status reset", int'(pin_status), 0);
        chk(cfg_rdata === 8'h00, "R1 cfg reset", int'(cfg_rdata), 0);
        chk(cfg_written === 1'b0, "R1 pulse reset", int'(cfg_written), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 pass-through, mode 00
        write_cfg(pack(0, 3, 5));
        toggle_and_measure(3, "R4 pass rise");
        toggle_and_measure(3, "R4 pass fall");

        // R5 R6 R7 both-direction filter, sweep tick size and count
        for (int sel = 0; sel < 2; sel++) begin
            for (int k = 0; k < 4; k++) begin
                int nn;
                nn = (k == 3) ? 0 : (k * 2 + 1);
                write_cfg(pack(1, sel, nn));
                full = ticks_of(nn) * len_of(sel) + 2;
                toggle_and_measure(full, "R7 both rise R5 R6");
                toggle_and_measure(full, "R7 both fall R5 R6");
            end
        end
        write_cfg(pack(1, 2, 1));
        toggle_and_measure(512 + 2, "R5 tick 512 rise");
        toggle_and_measure(512 + 2, "R5 tick 512 fall");
        write_cfg(pack(1, 3, 2));
        toggle_and_measure(4096 + 2, "R5 tick 2048 x2 rise");
        toggle_and_measure(4096 + 2, "R5 tick 2048 x2 fall");

        // R9 keep-low mode
        write_cfg(pack(2, 0, 3));
        toggle_and_measure(6 + 2, "R9 rise delayed");
        toggle_and_measure(3, "R9 fall immediate");

        // R10 keep-high mode
        write_cfg(pack(3, 1, 2));
        toggle_and_measure(3, "R10 rise immediate");
        toggle_and_measure(16 + 2, "R10 fall delayed");
        pad_in = 1'b0;
        write_cfg(pack(0, 0, 1));
        repeat (4) @(negedge clk);

        // R8 glitch one pulse short of the full time, then restart
        write_cfg(pack(1, 0, 4));
        stayed = 1'b1;
        pad_in = 1'b1;
        repeat (7) begin
            @(negedge clk);
            if (pin_status !== 1'b0) stayed = 1'b0;
        end
        pad_in = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (pin_status !== 1'b0) stayed = 1'b0;
        end
        chk(stayed, "R8 short glitch rejected", int'(pin_status), 0);
        toggle_and_measure(8 + 2, "R8 full time after glitch");

        // R11 write mid-count restarts the count
        pad_in = 1'b0;
        wait_change(20, n);
        chk(n == 10 && pin_status === 1'b0, "R11 setup fall", n, 10);
        pad_in = 1'b1;
        repeat (5) @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = pack(1, 0, 4);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        wait_change(20, n);
        chk(n == 8, "R11 restart after write", n, 8);

        // R7 stall while no slow pulses
        write_cfg(pack(1, 0, 1));
        rtc_pulse = 1'b0;
        pad_in = 1'b0;
        repeat (50) @(negedge clk);
        chk(pin_status === 1'b1, "R7 stall holds", int'(pin_status), 1);
        rtc_pulse = 1'b1;
        wait_change(20, n);
        chk(n == 2, "R7 resume after stall", n, 2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule